// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns the system clock into time quanta and walks every nominal bit through three segments: a one-quantum sync segment, a configurable first time segment (propagation plus first phase segment) and a configurable second time segment. At the boundary between the two time segments it samples the synchronized receive line and hands the value upward with a one-cycle strobe. At the start of every bit it loads the next transmit bit onto the output line and pulses a boundary strobe, so a bit-stream processor can feed one bit per strobe.

Falling (recessive-to-dominant) edges on the receive line keep the node locked to the bus. When the bit-stream processor raises its hard-sync request, such an edge restarts the bit so that the edge lies in the sync segment. Any other edge is measured in quanta against the current bit position. An edge before the sample point stretches the first time segment. An edge after it is taken as an early edge of the next bit and cuts the second time segment short. Either correction is capped by the jump width and lasts for the current bit only.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `cfg_brp`+1 clock cycles. With T1 = `cfg_ts1`+1 and T2 = `cfg_ts2`+1, an uncorrected bit lasts (1+T1+T2) quanta between successive `bit_start_stb` pulses.
- R2: `sample_stb` is a one-cycle pulse (1+T1) quanta after the bit start. In the same cycle `rx_bit` shows the synchronized receive level at the sample point (1 = recessive, 0 = dominant). `sample_stb` and `bit_start_stb` are never high together.
- R3: With each `bit_start_stb` pulse, `tx_out` takes the value of `tx_bit` and holds it until the next pulse.
- R4: The receive line passes two synchronizer flops. A falling edge seen while `hard_sync_req` is high restarts the sync segment on the third clock after `rx_in` falls. The sample strobe then follows (1+T1) quanta later.
- R5: A falling edge that reaches the block in quantum q (counted from 0) of the first time segment lengthens that segment by min(q+1, `cfg_sjw`+1) quanta.
- R6: A falling edge in quantum q of the second time segment shortens it by min(T2-1-q, `cfg_sjw`+1) quanta.
- R7: At most one correction is applied per bit. A second falling edge in the same bit has no effect on timing.
- R8: No correction is made while `tx_out` is 0 (dominant).
- R9: While `rst` is high, `tx_out` and `rx_bit` are 1 and both strobes are 0.
- R10: A correction affects only the bit in which it happens. The following bit has nominal length.
- R11: An edge that arrives in the same cycle as the quantum tick that would end the first time segment still lengthens it. The sample is then taken later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_brp | input | BRP_W | Prescaler; quantum = cfg_brp+1 clocks |
| cfg_ts1 | input | SEG1_W | First time segment length minus one, in quanta |
| cfg_ts2 | input | SEG2_W | Second time segment length minus one, in quanta |
| cfg_sjw | input | SJW_W | Jump width minus one, in quanta |
| rx_in | input | 1 | Raw receive line from the transceiver |
| hard_sync_req | input | 1 | Next falling edge performs a hard sync |
| tx_bit | input | 1 | Bit to drive at the next bit start |
| tx_out | output | 1 | Transmit line to the transceiver |
| rx_bit | output | 1 | Sampled receive bit |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| bit_start_stb | output | 1 | One-cycle pulse at each bit start |

## Verification
The clash that matters is a resynchronizing edge that lands in the very cycle in which the quantum tick would close a segment. The length update and the end-of-segment decision then compete. The bench provokes this by timing the `rx_in` drop so the edge reaches the block exactly on the last tick of the first segment, and also on a tick inside the second segment. It judges the result by the cycle of the next `sample_stb` and `bit_start_stb`, predicted from R5, R6 and R11. Other cases fire edges mid-quantum, beyond the jump width, while transmitting dominant, twice in one bit, and under a second configuration.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  // Bit segment currently being timed
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_s,
  output logic rx_fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= rx_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], rx_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rx_s    = chain_q[STAGES-1];
  assign rx_fall = prev_q & ~rx_s;
endmodule

// File: rtl/cbt_tq_gen.sv
module cbt_tq_gen #(
  parameter int BRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BRP_W-1:0] brp,
  input  logic             restart,
  output logic             tick
);
  logic [BRP_W-1:0] cnt_q;

  assign tick = (cnt_q >= brp);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + BRP_W'(1);
  end

  // R1: the divider never runs past the programmed prescaler
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= brp);
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEG1_W-1:0] cfg_ts1,
  input  logic [SEG2_W-1:0] cfg_ts2,
  input  logic [SJW_W-1:0]  cfg_sjw,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              rx_fall,
  input  logic              hard_sync_req,
  input  logic              tx_bit,
  output logic              tx_out,
  output logic              rx_bit,
  output logic              sample_stb,
  output logic              bit_start_stb
);
  seg_e             seg_q;
  logic [LEN_W-1:0] q_q, ts1_len_q, ts2_len_q;
  logic [LEN_W-1:0] ts1_base, ts2_base, sjw_len;
  logic [LEN_W-1:0] e1, e2, adj1, adj2, ts1_eff, ts2_eff;
  logic             done_q, hs, rs_ok;

  assign ts1_base = LEN_W'(cfg_ts1) + LEN_W'(1);
  assign ts2_base = LEN_W'(cfg_ts2) + LEN_W'(1);
  assign sjw_len  = LEN_W'(cfg_sjw) + LEN_W'(1);
  assign hs       = rx_fall & hard_sync_req;
  assign rs_ok    = rx_fall & ~hard_sync_req & ~done_q & tx_out;

  // Phase error in quanta and its jump-width-limited correction
  always_comb begin
    e1      = q_q + LEN_W'(1);
    e2      = ts2_len_q - q_q - LEN_W'(1);
    adj1    = (e1 < sjw_len) ? e1 : sjw_len;
    adj2    = (e2 < sjw_len) ? e2 : sjw_len;
    ts1_eff = ts1_len_q;
    ts2_eff = ts2_len_q;
    if (rs_ok && seg_q == SEG_TS1) ts1_eff = ts1_len_q + adj1;
    if (rs_ok && seg_q == SEG_TS2) ts2_eff = ts2_len_q - adj2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q         <= SEG_SYNC;
      q_q           <= '0;
      ts1_len_q     <= ts1_base;
      ts2_len_q     <= ts2_base;
      done_q        <= 1'b0;
      tx_out        <= 1'b1;
      rx_bit        <= 1'b1;
      sample_stb    <= 1'b0;
      bit_start_stb <= 1'b0;
    end else begin
      sample_stb    <= 1'b0;
      bit_start_stb <= 1'b0;
      if (hs) begin
        seg_q     <= SEG_SYNC;
        q_q       <= '0;
        ts1_len_q <= ts1_base;
        ts2_len_q <= ts2_base;
        done_q    <= 1'b1;
      end else begin
        if (rs_ok) begin
          done_q <= 1'b1;
          if (seg_q == SEG_TS1) ts1_len_q <= ts1_eff;
          if (seg_q == SEG_TS2) ts2_len_q <= ts2_eff;
        end
        if (tick) begin
          unique case (seg_q)
            SEG_SYNC: begin
              seg_q <= SEG_TS1;
              q_q   <= '0;
            end
            SEG_TS1: begin
              if (q_q >= ts1_eff - LEN_W'(1)) begin
                seg_q      <= SEG_TS2;
                q_q        <= '0;
                sample_stb <= 1'b1;
                rx_bit     <= rx_s;
              end else begin
                q_q <= q_q + LEN_W'(1);
              end
            end
            SEG_TS2: begin
              if (q_q >= ts2_eff - LEN_W'(1)) begin
                seg_q         <= SEG_SYNC;
                q_q           <= '0;
                bit_start_stb <= 1'b1;
                tx_out        <= tx_bit;
                ts1_len_q     <= ts1_base;
                ts2_len_q     <= ts2_base;
                done_q        <= 1'b0;
              end else begin
                q_q <= q_q + LEN_W'(1);
              end
            end
            default: begin
              seg_q <= SEG_SYNC;
              q_q   <= '0;
            end
          endcase
        end
      end
    end
  end

  // R2: sample point and bit boundary never share a cycle
  p_stb_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_start_stb));

  // R3: the transmit line only moves on a bit boundary
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_out != $past(tx_out)) |-> bit_start_stb);

  // R4: the sync segment lasts exactly one quantum
  p_sync_one_tq_r4: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_SYNC && tick && !hs) |=> (seg_q == SEG_TS1));

  // R5: stretched first segment stays within the jump width
  p_ts1_limit_r5: assert property (@(posedge clk) disable iff (rst)
    ts1_len_q <= ts1_base + sjw_len);

  // R6: shortened second segment loses at most the jump width
  p_ts2_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (ts2_len_q + sjw_len >= ts2_base) && (ts2_len_q != '0));

  // R7: a segment length changes inside a bit only if no correction was made yet
  p_one_adj_r7: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_TS1 && $past(seg_q) == SEG_TS1 && ts1_len_q != $past(ts1_len_q))
      |-> !$past(done_q));

  // R8: no stretch while the node drives dominant
  p_no_adj_dom_r8: assert property (@(posedge clk) disable iff (rst)
    (ts1_len_q > $past(ts1_len_q)) |-> $past(tx_out));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W     = 8,
  parameter int SEG1_W    = 4,
  parameter int SEG2_W    = 3,
  parameter int SJW_W     = 2,
  parameter int RX_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BRP_W-1:0]  cfg_brp,
  input  logic [SEG1_W-1:0] cfg_ts1,
  input  logic [SEG2_W-1:0] cfg_ts2,
  input  logic [SJW_W-1:0]  cfg_sjw,
  input  logic              rx_in,
  input  logic              hard_sync_req,
  input  logic              tx_bit,
  output logic              tx_out,
  output logic              rx_bit,
  output logic              sample_stb,
  output logic              bit_start_stb
);
  localparam int SEG_MAX_W = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
  localparam int LEN_W     = ((SEG_MAX_W > SJW_W) ? SEG_MAX_W : SJW_W) + 2;

  logic rx_s, rx_fall, tick, restart;

  assign restart = rx_fall & hard_sync_req;

  cbt_rx_sync #(.STAGES(RX_STAGES)) u_rx_sync (
    .clk     (clk),
    .rst     (rst),
    .rx_in   (rx_in),
    .rx_s    (rx_s),
    .rx_fall (rx_fall)
  );

  cbt_tq_gen #(.BRP_W(BRP_W)) u_tq_gen (
    .clk     (clk),
    .rst     (rst),
    .brp     (cfg_brp),
    .restart (restart),
    .tick    (tick)
  );

  cbt_seg_fsm #(
    .SEG1_W (SEG1_W),
    .SEG2_W (SEG2_W),
    .SJW_W  (SJW_W),
    .LEN_W  (LEN_W)
  ) u_seg_fsm (
    .clk           (clk),
    .rst           (rst),
    .cfg_ts1       (cfg_ts1),
    .cfg_ts2       (cfg_ts2),
    .cfg_sjw       (cfg_sjw),
    .tick          (tick),
    .rx_s          (rx_s),
    .rx_fall       (rx_fall),
    .hard_sync_req (hard_sync_req),
    .tx_bit        (tx_bit),
    .tx_out        (tx_out),
    .rx_bit        (rx_bit),
    .sample_stb    (sample_stb),
    .bit_start_stb (bit_start_stb)
  );
endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  localparam int BRP_W  = 8;
  localparam int SEG1_W = 4;
  localparam int SEG2_W = 3;
  localparam int SJW_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BRP_W-1:0]  cfg_brp = '0;
  logic [SEG1_W-1:0] cfg_ts1 = '0;
  logic [SEG2_W-1:0] cfg_ts2 = '0;
  logic [SJW_W-1:0]  cfg_sjw = '0;
  logic rx_in = 1'b1, hard_sync_req = 1'b0, tx_bit = 1'b1;
  logic tx_out, rx_bit, sample_stb, bit_start_stb;

  always #10 clk = ~clk;

  can_bit_timer #(.BRP_W(BRP_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_brp(cfg_brp), .cfg_ts1(cfg_ts1), .cfg_ts2(cfg_ts2),
    .cfg_sjw(cfg_sjw), .rx_in(rx_in), .hard_sync_req(hard_sync_req), .tx_bit(tx_bit),
    .tx_out(tx_out), .rx_bit(rx_bit), .sample_stb(sample_stb), .bit_start_stb(bit_start_stb)
  );

  typedef struct {
    bit    smp;
    int    t;
    bit    v;
    string req;
  } ev_t;

  ev_t   exp_q[$];
  int    rx_t[$];
  bit    rx_v[$];
  int    cyc = 0;
  int    n_chk = 0, n_err = 0;
  bit    armed = 0;
  int    Q, T1, T2, SJ;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic at_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Level of the synchronized line read by a sample registered at edge s
  function automatic bit rx_at(input int s);
    bit v = 1'b1;
    int best = -1;
    for (int i = 0; i < rx_t.size(); i++)
      if (rx_t[i] <= s - 3 && rx_t[i] > best) begin
        best = rx_t[i];
        v    = rx_v[i];
      end
    return v;
  endfunction

  // Monitor: pop expected strobes as they appear
  always @(negedge clk) begin
    ev_t e;
    if (armed && (sample_stb || bit_start_stb)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected strobe at cycle", cyc, -1);
      end else begin
        e = exp_q.pop_front();
        check(sample_stb == e.smp && bit_start_stb != e.smp, e.req, "strobe kind", int'(sample_stb), int'(e.smp));
        check(cyc == e.t, e.req, "strobe cycle", cyc, e.t);
        if (e.smp) check(rx_bit == e.v, e.req, "rx_bit", int'(rx_bit), int'(e.v));
        else       check(tx_out == e.v, e.req, "tx_out", int'(tx_out), int'(e.v));
      end
    end
  end

  task automatic apply_cfg(input int brp, input int ts1, input int ts2, input int sjw);
    @(negedge clk);
    rst = 1'b1;
    cfg_brp = BRP_W'(brp); cfg_ts1 = SEG1_W'(ts1); cfg_ts2 = SEG2_W'(ts2); cfg_sjw = SJW_W'(sjw);
    Q = brp + 1; T1 = ts1 + 1; T2 = ts2 + 1; SJ = sjw + 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // Driver: hard sync, then one bit with an edge in quantum index k (0 = sync)
  task automatic scn(input int k, input int off, input bit txd, input int k2, input string rq);
    int n, h, s0, b1, rise0, a, a2, ext, shr, q0, s1, b2, s2, b3;
    rx_t.delete(); rx_v.delete();
    n = cyc + 4; h = n + 3;
    s0 = h + (1 + T1) * Q;
    b1 = h + (1 + T1 + T2) * Q;
    rise0 = s0 + 2;
    a  = b1 + k * Q + off + 1;
    a2 = b1 + k2 * Q + 2;
    rx_t.push_back(n);     rx_v.push_back(1'b0);
    rx_t.push_back(rise0); rx_v.push_back(1'b1);
    rx_t.push_back(a - 3); rx_v.push_back(1'b0);
    if (k2 > 0) begin
      rx_t.push_back(a2 - 8); rx_v.push_back(1'b1);
      rx_t.push_back(a2 - 3); rx_v.push_back(1'b0);
    end
    ext = 0; shr = 0;
    if (!txd) begin
      if (k >= 1 && k <= T1) ext = (k < SJ) ? k : SJ;
      else if (k > T1) begin
        q0  = k - 1 - T1;
        shr = ((T2 - 1 - q0) < SJ) ? (T2 - 1 - q0) : SJ;
      end
    end
    s1 = b1 + (1 + T1 + ext) * Q;
    b2 = b1 + (1 + T1 + T2 + ext - shr) * Q;
    s2 = b2 + (1 + T1) * Q;
    b3 = b2 + (1 + T1 + T2) * Q;
    exp_q.push_back('{1'b1, s0, rx_at(s0), "R4"});
    exp_q.push_back('{1'b0, b1, !txd, "R3"});
    exp_q.push_back('{1'b1, s1, rx_at(s1), rq});
    exp_q.push_back('{1'b0, b2, 1'b1, rq});
    exp_q.push_back('{1'b1, s2, rx_at(s2), "R10"});
    exp_q.push_back('{1'b0, b3, 1'b1, "R10"});

    at_cyc(n);      rx_in = 1'b0; hard_sync_req = 1'b1; tx_bit = !txd;
    at_cyc(h);      hard_sync_req = 1'b0; armed = 1'b1;
    at_cyc(rise0);  rx_in = 1'b1;
    at_cyc(a - 3);  rx_in = 1'b0;
    if (k2 > 0) begin
      at_cyc(a2 - 8); rx_in = 1'b1;
      at_cyc(a2 - 3); rx_in = 1'b0;
    end
    if (cyc < b1) at_cyc(b1);
    tx_bit = 1'b1;
    at_cyc(b3 + 2);
    check(exp_q.size() == 0, rq, "pending strobes", exp_q.size(), 0);
    exp_q.delete();
    armed = 1'b0;
    rx_in = 1'b1;
    at_cyc(cyc + 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog: got cycle %0d expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    cfg_brp = 8'd3; cfg_ts1 = 4'd5; cfg_ts2 = 3'd3; cfg_sjw = 2'd1;
    Q = 4; T1 = 6; T2 = 4; SJ = 2;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(tx_out == 1'b1, "R9", "tx_out in reset", int'(tx_out), 1);
    check(rx_bit == 1'b1, "R9", "rx_bit in reset", int'(rx_bit), 1);
    check(sample_stb == 1'b0, "R9", "sample_stb in reset", int'(sample_stb), 0);
    check(bit_start_stb == 1'b0, "R9", "bit_start_stb in reset", int'(bit_start_stb), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    scn(0, 1, 1'b0, 0, "R1");   // edge in sync segment: nominal bit
    scn(1, 1, 1'b0, 0, "R5");   // TS1 q0: stretch by 1
    scn(4, 0, 1'b0, 0, "R5");   // TS1 q3: stretch capped at jump width
    scn(6, 3, 1'b0, 0, "R11");  // edge on the tick closing TS1
    scn(8, 1, 1'b0, 0, "R6");   // TS2 q1: shorten by 2
    scn(9, 3, 1'b0, 0, "R6");   // TS2 q2 on a tick: shorten by 1
    scn(7, 0, 1'b0, 0, "R6");   // TS2 q0: shorten capped
    scn(3, 2, 1'b1, 0, "R8");   // dominant transmit: no correction
    scn(2, 0, 1'b0, 9, "R7");   // second edge in same bit ignored

    apply_cfg(1, 3, 2, 0);      // Q=2, T1=4, T2=3, jump 1
    scn(2, 1, 1'b0, 0, "R1");
    scn(5, 0, 1'b0, 0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule